// File: doc/BRIEF.md
# Internal Composite Sync Generator

This block produces the line and field timing for an on-screen display that has to run with no incoming video. From a crystal clock at twice or four times the colour subcarrier it builds a horizontal sync pulse, a vertical sync interval, a composite sync waveform, a field-parity flag and a blanking strobe. It also marks the picture area in which a full-screen background colour is painted. The downstream analog stage turns these strobes into video levels. That stage is outside this block.

The clock-rate bit doubles every horizontal count. This lets one set of counters serve both crystal options. The interlace bit chooses between a 263-line progressive field and a field that ends half-way through a line, so that successive fields interleave. The standard-select input decides whether a green background may be chosen, because green is offered only in NTSC. When the internal/external select picks external sync, the counters are held at the start of a field and every strobe stays low.

Vertical position is counted in half-lines. One counter therefore covers both field lengths and all the half-line pulse trains of the vertical interval.

Top module: `osd_sync_gen`

## Requirements
- R1: With `clk_4fsc` low a line lasts LINE_2X clocks (455 by default). With it high a line lasts twice that (910). `hsync` is high for the first HSYNC_2X clocks of each line, and that width also doubles when `clk_4fsc` is high.
- R2: With `interlace` low a field lasts 2*LINES half-lines, which is 263 full lines by default. Every field starts at the beginning of a line.
- R3: With `interlace` high a field lasts 2*LINES-1 half-lines. Successive fields therefore start alternately at the beginning and at the middle of a line (half point = line length / 2).
- R4: `csync` follows `hsync` outside the vertical interval. During the broad region each half-line carries a pulse of (half-line length − hsync width) clocks. In interlaced mode each half-line of the EQ_HALVES half-lines before and after the broad region carries a pulse half the hsync width. In non-interlaced mode those half-lines carry plain `hsync`.
- R5: `vsync` is high for VS_HALVES half-lines, starting EQ_HALVES half-lines after the field start.
- R6: In interlaced mode `field` inverts in the cycle in which `vsync` rises. In non-interlaced mode `field` is 0, and clearing takes priority over inverting.
- R7: While `int_sync` is low, every output is 0 and the counters are held at the start of a field. When `int_sync` goes high again, the first cycle is the first clock of a line, with `hsync` high.
- R8: `blank` is high during the first VBLANK_HALVES half-lines of a field and during the first HBLANK_2X clocks of each line (doubled at 4fsc). `bg_en` is high exactly when internal sync is selected and `blank` is low.
- R9: `bg_green` is high only when `bg_en` is high, `bg_green_req` is high and `std_palm` is low (NTSC). In PAL-M the background is always blue (`bg_green` = 0).
- R10: While `rst_n` is low, the counters sit at the start of a field and `field` is 0. With internal sync selected, this shows as `hsync` = 1, `vsync` = 0 and `blank` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, 2fsc or 4fsc |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_sync | input | 1 | 1 = internal sync generation, 0 = external (outputs quiet) |
| std_palm | input | 1 | 0 = NTSC, 1 = PAL-M |
| interlace | input | 1 | 1 = interlaced half-line fields, 0 = 263-line fields |
| clk_4fsc | input | 1 | 0 = clock is 2fsc, 1 = clock is 4fsc |
| bg_green_req | input | 1 | Requests a green background instead of blue |
| csync | output | 1 | Composite sync, active high |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync interval, active high |
| field | output | 1 | Field parity |
| blank | output | 1 | Horizontal or vertical blanking |
| bg_en | output | 1 | Background-colour region |
| bg_green | output | 1 | Background colour is green (else blue) |

## Verification
The field-parity flip and the start of `vsync` fall on the same edge, and so does the clearing of `field` when the interlace bit drops. The bench drops `interlace` and changes the clock rate while fields are running, so such edges land on arbitrary counter positions. A scoreboard model, written from the requirements, predicts every output in every cycle, including which of clear and invert wins. On interlaced fields the half-line start of the second field also puts a `vsync` rise in the middle of a line. The bench judges this by the distance from the last `hsync` rise, which must alternate between 0 and half a line.

// File: rtl/osg_pkg.sv
package osg_pkg;
   typedef enum logic [1:0] {
      RG_NORMAL  = 2'd0,
      RG_PRE_EQ  = 2'd1,
      RG_BROAD   = 2'd2,
      RG_POST_EQ = 2'd3
   } vregion_t;
endpackage

// File: rtl/osg_line_timer.sv
module osg_line_timer #(
   parameter int unsigned LINE_2X = 455,
   parameter int unsigned CW      = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          fast,
   output logic [CW-1:0] hcnt,
   output logic [CW-1:0] half_len,
   output logic          half_end
);
   localparam logic [CW-1:0] LEN_SLOW = CW'(LINE_2X);
   localparam logic [CW-1:0] LEN_FAST = CW'(2 * LINE_2X);
   localparam logic [CW-1:0] ONE      = CW'(1);

   logic [CW-1:0] line_len;
   logic          at_end;

   assign line_len = fast ? LEN_FAST : LEN_SLOW;
   assign half_len = line_len >> 1;
   // >= keeps the counter safe when the rate bit shrinks the line mid-way
   assign at_end   = (hcnt >= line_len - ONE);
   assign half_end = run && (at_end || (hcnt == half_len - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hcnt <= '0;
      else if (!run)   hcnt <= '0;
      else if (at_end) hcnt <= '0;
      else             hcnt <= hcnt + ONE;
   end
endmodule

// File: rtl/osg_field_timer.sv
module osg_field_timer
   import osg_pkg::*;
#(
   parameter int unsigned LINES     = 263,
   parameter int unsigned EQ_HALVES = 6,
   parameter int unsigned VS_HALVES = 6,
   parameter int unsigned VW        = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          interlace,
   input  logic          half_end,
   output logic [VW-1:0] vh,
   output logic          field_q,
   output vregion_t      region
);
   localparam logic [VW-1:0] LAST_NI = VW'(2 * LINES - 1);
   localparam logic [VW-1:0] LAST_IL = VW'(2 * LINES - 2);
   localparam logic [VW-1:0] EQ_END  = VW'(EQ_HALVES);
   localparam logic [VW-1:0] BR_END  = VW'(EQ_HALVES + VS_HALVES);
   localparam logic [VW-1:0] PO_END  = VW'(2 * EQ_HALVES + VS_HALVES);

   logic [VW-1:0] vh_last, vh_next;

   assign vh_last = interlace ? LAST_IL : LAST_NI;
   assign vh_next = (vh >= vh_last) ? '0 : vh + VW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vh      <= '0;
         field_q <= 1'b0;
      end else if (!run) begin
         vh      <= '0;
         field_q <= 1'b0;
      end else begin
         if (half_end) vh <= vh_next;
         if (!interlace)                          field_q <= 1'b0;
         else if (half_end && vh_next == EQ_END)  field_q <= ~field_q;
      end
   end

   always_comb begin
      if (vh < EQ_END)      region = RG_PRE_EQ;
      else if (vh < BR_END) region = RG_BROAD;
      else if (vh < PO_END) region = RG_POST_EQ;
      else                  region = RG_NORMAL;
   end
endmodule

// File: rtl/osg_wave_decode.sv
module osg_wave_decode
   import osg_pkg::*;
#(
   parameter int unsigned HSYNC_2X      = 34,
   parameter int unsigned HBLANK_2X     = 78,
   parameter int unsigned VBLANK_HALVES = 40,
   parameter int unsigned CW            = 10,
   parameter int unsigned VW            = 10
) (
   input  logic          run,
   input  logic          fast,
   input  logic          interlace,
   input  logic          palm,
   input  logic          green_req,
   input  logic [CW-1:0] hcnt,
   input  logic [CW-1:0] half_len,
   input  logic [VW-1:0] vh,
   input  logic          field_q,
   input  vregion_t      region,
   output logic          csync,
   output logic          hsync,
   output logic          vsync,
   output logic          field,
   output logic          blank,
   output logic          bg_en,
   output logic          bg_green
);
   localparam logic [VW-1:0] VB_END = VW'(VBLANK_HALVES);

   logic [CW-1:0] hw, eqw, hbw, hp;
   logic          hs_raw, cs_raw, bl_raw;

   assign hw  = fast ? CW'(2 * HSYNC_2X)  : CW'(HSYNC_2X);
   assign hbw = fast ? CW'(2 * HBLANK_2X) : CW'(HBLANK_2X);
   assign eqw = hw >> 1;
   assign hp  = (hcnt < half_len) ? hcnt : hcnt - half_len;

   assign hs_raw = (hcnt < hw);
   assign bl_raw = (vh < VB_END) || (hcnt < hbw);

   always_comb begin
      unique case (region)
         RG_BROAD:              cs_raw = (hp < half_len - hw);
         RG_PRE_EQ, RG_POST_EQ: cs_raw = interlace ? (hp < eqw) : hs_raw;
         default:               cs_raw = hs_raw;
      endcase
   end

   assign csync    = run & cs_raw;
   assign hsync    = run & hs_raw;
   assign vsync    = run & (region == RG_BROAD);
   assign field    = run & field_q;
   assign blank    = run & bl_raw;
   assign bg_en    = run & ~bl_raw;
   assign bg_green = run & ~bl_raw & green_req & ~palm;
endmodule

// File: rtl/osd_sync_gen.sv
module osd_sync_gen
   import osg_pkg::*;
#(
   parameter int unsigned LINE_2X       = 455,
   parameter int unsigned HSYNC_2X      = 34,
   parameter int unsigned HBLANK_2X     = 78,
   parameter int unsigned LINES         = 263,
   parameter int unsigned EQ_HALVES     = 6,
   parameter int unsigned VS_HALVES     = 6,
   parameter int unsigned VBLANK_HALVES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic int_sync,
   input  logic std_palm,
   input  logic interlace,
   input  logic clk_4fsc,
   input  logic bg_green_req,
   output logic csync,
   output logic hsync,
   output logic vsync,
   output logic field,
   output logic blank,
   output logic bg_en,
   output logic bg_green
);
   localparam int unsigned CW = $clog2(2 * LINE_2X + 1);
   localparam int unsigned VW = $clog2(2 * LINES + 1);

   // elaboration-time parameter checks
   if (HSYNC_2X < 2) begin : g_bad_hsync_min
      $error("HSYNC_2X must be at least 2");
   end
   if (LINE_2X < 4 * HSYNC_2X + 2) begin : g_bad_line
      $error("LINE_2X too short for broad pulses");
   end
   if (HBLANK_2X <= HSYNC_2X || HBLANK_2X >= LINE_2X / 2) begin : g_bad_hblank
      $error("HBLANK_2X must lie between HSYNC_2X and half a line");
   end
   if (EQ_HALVES < 1 || VS_HALVES < 1) begin : g_bad_vint
      $error("EQ_HALVES and VS_HALVES must be non-zero");
   end
   if (2 * EQ_HALVES + VS_HALVES > VBLANK_HALVES || VBLANK_HALVES >= 2 * LINES - 1) begin : g_bad_vblank
      $error("VBLANK_HALVES must cover the vertical interval and fit in a field");
   end

   logic [CW-1:0] hcnt, half_len;
   logic          half_end;
   logic [VW-1:0] vh;
   logic          field_q;
   vregion_t      region;

   osg_line_timer #(.LINE_2X(LINE_2X), .CW(CW)) u_line (
      .clk(clk), .rst_n(rst_n), .run(int_sync), .fast(clk_4fsc),
      .hcnt(hcnt), .half_len(half_len), .half_end(half_end)
   );

   osg_field_timer #(.LINES(LINES), .EQ_HALVES(EQ_HALVES),
                     .VS_HALVES(VS_HALVES), .VW(VW)) u_field (
      .clk(clk), .rst_n(rst_n), .run(int_sync), .interlace(interlace),
      .half_end(half_end), .vh(vh), .field_q(field_q), .region(region)
   );

   osg_wave_decode #(.HSYNC_2X(HSYNC_2X), .HBLANK_2X(HBLANK_2X),
                     .VBLANK_HALVES(VBLANK_HALVES), .CW(CW), .VW(VW)) u_wave (
      .run(int_sync), .fast(clk_4fsc), .interlace(interlace), .palm(std_palm),
      .green_req(bg_green_req), .hcnt(hcnt), .half_len(half_len), .vh(vh),
      .field_q(field_q), .region(region),
      .csync(csync), .hsync(hsync), .vsync(vsync), .field(field),
      .blank(blank), .bg_en(bg_en), .bg_green(bg_green)
   );
endmodule

// File: rtl/osg_checker.sv
module osg_checker (
   input logic clk,
   input logic rst_n,
   input logic int_sync,
   input logic std_palm,
   input logic interlace,
   input logic csync,
   input logic hsync,
   input logic vsync,
   input logic field,
   input logic blank,
   input logic bg_en,
   input logic bg_green
);
   p_ext_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !int_sync |-> !(csync || hsync || vsync || field || blank || bg_en || bg_green));

   p_green_ntsc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bg_green |-> (!std_palm && bg_en));

   p_field_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (field != $past(field)) |-> ($rose(vsync) || !$past(interlace) || !$past(int_sync)));

   p_field_ni_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!interlace && int_sync) |=> !field);

   p_broad_csync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && hsync) |-> csync);

   p_vsync_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> (blank && !bg_en));
endmodule

bind osd_sync_gen osg_checker u_chk (.*);

// File: tb/tb_osd_sync_gen.sv
`timescale 1ns/1ps
module tb_osd_sync_gen;
   localparam int LN = 20, HS = 3, HB = 6, NL = 11, EQ = 2, VS = 2, VB = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, int_s = 1'b1, palm = 1'b0, il = 1'b0, fast = 1'b0, greq = 1'b1;
   logic nx_rst_n = 1'b0, nx_int = 1'b1, nx_palm = 1'b0, nx_il = 1'b0, nx_fast = 1'b0, nx_greq = 1'b1;
   logic csync, hsync, vsync, field, blank, bg_en, bg_green;

   osd_sync_gen #(.LINE_2X(LN), .HSYNC_2X(HS), .HBLANK_2X(HB), .LINES(NL),
                  .EQ_HALVES(EQ), .VS_HALVES(VS), .VBLANK_HALVES(VB)) dut (
      .clk(clk), .rst_n(rst_n), .int_sync(int_s), .std_palm(palm), .interlace(il),
      .clk_4fsc(fast), .bg_green_req(greq), .csync(csync), .hsync(hsync),
      .vsync(vsync), .field(field), .blank(blank), .bg_en(bg_en), .bg_green(bg_green));

   logic full_fast = 1'b0;
   logic f_cs, f_hs, f_vs, f_fd, f_bl, f_bg, f_gr;
   osd_sync_gen dut_full (
      .clk(clk), .rst_n(rst_n), .int_sync(1'b1), .std_palm(1'b0), .interlace(1'b0),
      .clk_4fsc(full_fast), .bg_green_req(1'b0), .csync(f_cs), .hsync(f_hs),
      .vsync(f_vs), .field(f_fd), .blank(f_bl), .bg_en(f_bg), .bg_green(f_gr));

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- reference model from the requirements ----------------
   int m_hc = 0, m_vh = 0;
   bit m_fld = 0;
   logic [6:0] expq[$];

   function automatic void model_reset();
      m_hc = 0; m_vh = 0; m_fld = 0;
   endfunction

   function automatic void model_advance();
      int L, H, lastv, nvh;
      bit be;
      if (!rst_n || !int_s) begin model_reset(); return; end
      L = fast ? 2*LN : LN; H = L/2;
      lastv = il ? 2*NL-2 : 2*NL-1;
      be = (m_hc >= L-1) || (m_hc == H-1);
      nvh = (m_vh >= lastv) ? 0 : m_vh + 1;
      if (!il) m_fld = 0;
      else if (be && nvh == EQ) m_fld = ~m_fld;
      if (be) m_vh = nvh;
      m_hc = (m_hc >= L-1) ? 0 : m_hc + 1;
   endfunction

   function automatic logic [6:0] model_out();
      int L, H, hw, hp, hbw;
      bit hs, cs, vs, bl;
      if (!int_s) return 7'b0;
      L = fast ? 2*LN : LN; H = L/2;
      hw = fast ? 2*HS : HS; hbw = fast ? 2*HB : HB;
      hp = (m_hc < H) ? m_hc : m_hc - H;
      hs = m_hc < hw;
      vs = (m_vh >= EQ) && (m_vh < EQ+VS);
      if (vs) cs = hp < H - hw;
      else if (il && (m_vh < 2*EQ+VS)) cs = hp < hw/2;
      else cs = hs;
      bl = (m_vh < VB) || (m_hc < hbw);
      return {cs, hs, vs, m_fld, bl, !bl, (!bl && greq && !palm)};
   endfunction

   task automatic tick();
      @(posedge clk);
      model_advance();
      #1;
      rst_n = nx_rst_n; int_s = nx_int; palm = nx_palm; il = nx_il; fast = nx_fast; greq = nx_greq;
      if (!rst_n) model_reset();
      expq.push_back(model_out());
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // ---------------- monitor: scoreboard compare and measurements ----------------
   int cyc = 0, last_hs = 0, hs_gap = 0, hs_start = 0, hs_width = 0;
   int last_vs = 0, vs_gap = 0, vs_start = 0, vs_width = 0, vs_off = 0, prev_vs_off = 0;
   bit vs_fld = 0, prev_vs_fld = 0, seen_field1 = 0, seen_green = 0, seen_bg = 0, ext_active = 0;
   logic p_hs = 0, p_vs = 0;
   int f_last = 0, f_gap = 0;
   logic p_fhs = 0;

   always @(negedge clk) begin
      logic [6:0] e, a;
      cyc++;
      if (expq.size() > 0) begin
         e = expq.pop_front();
         a = {csync, hsync, vsync, field, blank, bg_en, bg_green};
         check(a[6] == e[6], "R4 csync", a[6], e[6]);
         check(a[5] == e[5], "R1 hsync", a[5], e[5]);
         check(a[4] == e[4], "R5 vsync", a[4], e[4]);
         check(a[3] == e[3], "R6 field", a[3], e[3]);
         check(a[2:1] == e[2:1], "R8 blank/bg_en", a[2:1], e[2:1]);
         check(a[0] == e[0], "R9 bg_green", a[0], e[0]);
      end
      if (hsync && !p_hs) begin hs_gap = cyc - last_hs; last_hs = cyc; hs_start = cyc; end
      if (!hsync && p_hs) hs_width = cyc - hs_start;
      if (vsync && !p_vs) begin
         vs_gap = cyc - last_vs; last_vs = cyc; vs_start = cyc;
         prev_vs_off = vs_off; vs_off = cyc - last_hs;
         prev_vs_fld = vs_fld; vs_fld = field;
      end
      if (!vsync && p_vs) vs_width = cyc - vs_start;
      if (field) seen_field1 = 1;
      if (bg_green) seen_green = 1;
      if (bg_en) seen_bg = 1;
      if (csync || hsync || vsync || field || blank || bg_en || bg_green) ext_active = 1;
      p_hs = hsync; p_vs = vsync;
      if (f_hs && !p_fhs) begin f_gap = cyc - f_last; f_last = cyc; end
      p_fhs = f_hs;
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(100000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
   end

   initial begin
      // R10: reset state
      run(3);
      #1;
      check(hsync == 1 && vsync == 0 && blank == 1 && field == 0, "R10 reset state",
            {hsync, vsync, blank, field}, 4'b1010);
      nx_rst_n = 1'b1;

      // R2: non-interlaced, 2fsc, NTSC with green request
      seen_field1 = 0; seen_green = 0;
      run(1000);
      check(vs_gap == NL*LN, "R2 non-interlaced field length", vs_gap, NL*LN);
      check(!seen_field1, "R6 field stays 0 non-interlaced", seen_field1, 0);
      check(seen_green, "R9 green allowed in NTSC", seen_green, 1);
      check(vs_width == VS*LN/2, "R5 vsync width", vs_width, VS*LN/2);
      check(hs_width == HS, "R1 hsync width 2fsc", hs_width, HS);
      check(f_gap == 455, "R1 full line 2fsc", f_gap, 455);

      // R3/R6: interlaced
      nx_il = 1'b1;
      run(1000);
      check(vs_gap == (2*NL-1)*LN/2, "R3 interlaced field length", vs_gap, (2*NL-1)*LN/2);
      check((vs_off + prev_vs_off) == LN/2 && vs_off != prev_vs_off, "R3 half-line field start",
            vs_off, LN/2 - prev_vs_off);
      check(vs_fld != prev_vs_fld, "R6 field alternates", vs_fld, !prev_vs_fld);

      // R1/R2: 4fsc, interlace dropped mid-field
      nx_il = 1'b0; nx_fast = 1'b1; full_fast = 1'b1;
      run(1400);
      check(vs_gap == NL*2*LN, "R2 field length 4fsc", vs_gap, NL*2*LN);
      check(hs_gap == 2*LN, "R1 line length 4fsc", hs_gap, 2*LN);
      check(hs_width == 2*HS, "R1 hsync width 4fsc", hs_width, 2*HS);
      check(f_gap == 910, "R1 full line 4fsc", f_gap, 910);
      check(!field, "R6 field cleared after interlace off", field, 0);

      // R9: PAL-M never green
      nx_palm = 1'b1; nx_fast = 1'b0;
      run(2);
      seen_green = 0; seen_bg = 0;
      run(600);
      check(!seen_green, "R9 PAL-M background blue", seen_green, 0);
      check(seen_bg, "R8 background region present", seen_bg, 1);

      // R7: external sync quiet, then restart at line start
      nx_int = 1'b0; nx_il = 1'b1;
      run(2);
      ext_active = 0;
      run(60);
      check(!ext_active, "R7 outputs quiet in external mode", ext_active, 0);
      nx_int = 1'b1;
      run(1);
      #1;
      check(hsync == 1 && vsync == 0 && field == 0, "R7 restart at field start",
            {hsync, vsync, field}, 3'b100);
      run(500);
      run(2);
      finish_run();
   end
endmodule